// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block steps through a multi-register transfer between the register file and a data memory port that is 64 bits wide. A one-cycle start pulse captures a register-select mask, a base word address and a direction flag. The sequencer then issues one memory beat per cycle. Each beat moves one or two registers, and the selected registers are visited from the lowest index to the highest. Each beat carries a double-word address, a two-bit lane enable and the register indices for the lower and upper 32-bit lanes. In the same cycle the block drives the matching register-file strobes: writes for a load, reads for a store. Data moves directly between the register file and the memory lanes, and every beat completes in the cycle it is issued.

Consecutive selected registers go to consecutive word addresses, starting at the base. When the base sits on an odd word, the first beat uses only the upper lane and every later beat is double-word aligned. A stall output holds the integer pipeline for every beat except the last. A done pulse marks the last beat, or the cycle after the start pulse when the mask is empty.

Top module: `lsm_seq`

## Requirements
- R1: While rst_ni is low, mem_req_o, stall_o, done_o, mem_lane_o, rf_we_o and rf_re_o are all zero.
- R2: A start pulse accepted with a non-empty mask makes mem_req_o high from the next cycle, for one cycle per beat. stall_o is high in every beat cycle except the last.
- R3: Each selected register is transferred exactly once, in ascending index order. The j-th selected register (j counted from 0) uses word address base+4j. In a beat with both lanes enabled, rf_idx1_o is greater than rf_idx0_o.
- R4: With base bit 2 clear, every beat moves two registers: lane bit 0 is the word at an address with bit 2 clear and lane bit 1 is the word at an address with bit 2 set. A trailing single register uses lane 2'b01. The transfer takes ceil(n/2) beats for n registers.
- R5: With base bit 2 set, the first beat enables only lane 2'b10 and carries the lowest selected register. The transfer takes floor(n/2)+1 beats, which is one beat more than the aligned case when n is even.
- R6: done_o is high for exactly the last beat cycle, and stall_o is low in that cycle.
- R7: A start pulse with an all-zero mask raises done_o in the next cycle with no memory beat and no stall.
- R8: For store_i=1, mem_we_o is high and rf_re_o equals mem_lane_o while rf_we_o stays zero. For store_i=0, mem_we_o is low and rf_we_o equals mem_lane_o while rf_re_o stays zero.
- R9: start_i is ignored while a beat is being issued. The transfer in progress continues unchanged, and no second transfer follows it.
- R10: mem_addr_o equals the beat's first word address rounded down to a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when no beat is in progress |
| store_i | input | 1 | 1: registers to memory, 0: memory to registers |
| mask_i | input | NREG | Register select mask, bit k selects register k |
| base_i | input | AW | Base byte address, word aligned |
| stall_o | output | 1 | Holds the integer pipeline |
| done_o | output | 1 | Transfer complete |
| mem_req_o | output | 1 | Memory beat valid |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | AW | Double-word beat address |
| mem_lane_o | output | 2 | Lane enables: bit 0 lower word, bit 1 upper word |
| rf_we_o | output | 2 | Register write strobes per lane |
| rf_re_o | output | 2 | Register read strobes per lane |
| rf_idx0_o | output | IW | Register index for the lower lane |
| rf_idx1_o | output | IW | Register index for the upper lane |

## Verification
The assertions assume that the base address is word aligned whenever start_i is high. The address-step and lane-order properties only hold when this is so. The bench always clears the two low bits of every base it drives, and it picks the alignment only through bit 2. The bench also drives start pulses while a transfer is running, and it starts a new transfer in the cycle a zero-mask start completes. This covers both the ignored start and the accepted start, and the assertions permit both.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_EMPTY = 2'd2
  } lsm_state_e;

  localparam int LSM_LANES = 2;
  typedef logic [LSM_LANES-1:0] lsm_lane_t;
endpackage

// File: rtl/lsm_prio.sv
// Lowest-set-bit finder
module lsm_prio #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask_i[k]) idx_o = IW'(k);
    end
  end

  assign vld_o = |mask_i;
  assign oh_o  = mask_i & (~mask_i + N'(1));
endmodule

// File: rtl/lsm_beat.sv
// Plans one beat from the remaining mask and the word parity of the address
module lsm_beat
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] rem_i,
  input  logic            odd_word_i,
  output lsm_lane_t       lane_o,
  output logic [IW-1:0]   idx0_o,
  output logic [IW-1:0]   idx1_o,
  output logic [NREG-1:0] rem_next_o,
  output logic            step8_o
);
  logic [NREG-1:0] chain [LSM_LANES+1];
  logic [NREG-1:0] oh    [LSM_LANES];
  logic [IW-1:0]   idx   [LSM_LANES];
  logic            vld   [LSM_LANES];

  assign chain[0] = rem_i;

  for (genvar g = 0; g < LSM_LANES; g++) begin : g_pick
    lsm_prio #(.N(NREG), .IW(IW)) i_prio (
      .mask_i (chain[g]),
      .vld_o  (vld[g]),
      .idx_o  (idx[g]),
      .oh_o   (oh[g])
    );
    assign chain[g+1] = chain[g] & ~oh[g];
  end

  always_comb begin
    idx0_o = idx[0];
    if (odd_word_i) begin
      // lone first register in the upper lane
      lane_o     = {vld[0], 1'b0};
      idx1_o     = idx[0];
      rem_next_o = chain[1];
      step8_o    = 1'b0;
    end else begin
      lane_o     = {vld[1], vld[0]};
      idx1_o     = idx[1];
      rem_next_o = chain[LSM_LANES];
      step8_o    = 1'b1;
    end
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            store_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  output logic            stall_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [1:0]      mem_lane_o,
  output logic [1:0]      rf_we_o,
  output logic [1:0]      rf_re_o,
  output logic [IW-1:0]   rf_idx0_o,
  output logic [IW-1:0]   rf_idx1_o
);
  localparam logic [AW-1:0] DW_MASK = ~AW'(7);

  lsm_state_e      state_q, state_d;
  logic [NREG-1:0] rem_q, rem_d, rem_next;
  logic [AW-1:0]   addr_q, addr_d;
  logic            store_q, store_d;
  lsm_lane_t       lane;
  logic            step8, xfer, last;

  lsm_beat #(.NREG(NREG), .IW(IW)) i_beat (
    .rem_i      (rem_q),
    .odd_word_i (addr_q[2]),
    .lane_o     (lane),
    .idx0_o     (rf_idx0_o),
    .idx1_o     (rf_idx1_o),
    .rem_next_o (rem_next),
    .step8_o    (step8)
  );

  assign xfer = (state_q == ST_XFER);
  assign last = (rem_next == '0);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    store_d = store_q;
    if (xfer) begin
      rem_d  = rem_next;
      addr_d = addr_q + (step8 ? AW'(8) : AW'(4));
      if (last) state_d = ST_IDLE;
    end else begin
      state_d = ST_IDLE;
      if (start_i) begin
        state_d = (mask_i == '0) ? ST_EMPTY : ST_XFER;
        rem_d   = mask_i;
        addr_d  = base_i;
        store_d = store_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      store_q <= store_d;
    end
  end

  assign mem_req_o  = xfer;
  assign mem_we_o   = xfer & store_q;
  assign mem_addr_o = addr_q & DW_MASK;
  assign mem_lane_o = xfer ? lane : 2'b00;
  assign rf_we_o    = mem_lane_o & {2{~store_q}};
  assign rf_re_o    = mem_lane_o & {2{store_q}};
  assign stall_o    = xfer & ~last;
  assign done_o     = (xfer & last) | (state_q == ST_EMPTY);
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    base_lo_i,
  input logic          stall_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_lane_o,
  input logic [1:0]    rf_we_o,
  input logic [1:0]    rf_re_o,
  input logic [IW-1:0] rf_idx0_o,
  input logic [IW-1:0] rf_idx1_o
);
  // input premise: word-aligned base
  p_base_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> base_lo_i == 2'b00);

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (!stall_o && mem_lane_o == 2'b00));

  p_stall_beats_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> mem_req_o);

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(stall_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(8));

  p_lane_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_lane_o == 2'b11) |-> rf_idx1_o > rf_idx0_o);

  p_beat_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lane_o != 2'b00);

  p_done_unstalled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stall_o);

  p_done_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mem_req_o) |=> !mem_req_o);

  p_strobe_dir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rf_we_o | rf_re_o) == mem_lane_o) && $countones({|rf_we_o, |rf_re_o}) <= 1);

  p_addr_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .IW(IW)) i_lsm_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .base_lo_i  (base_i[1:0]),
  .stall_o    (stall_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_lane_o (mem_lane_o),
  .rf_we_o    (rf_we_o),
  .rf_re_o    (rf_re_o),
  .rf_idx0_o  (rf_idx0_o),
  .rf_idx1_o  (rf_idx1_o)
);

// File: tb/test_lsm_seq.sv
`timescale 1ns/1ps
module test_lsm_seq;
  localparam int NREG = 16;
  localparam int AW   = 32;
  localparam int IW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            start, store;
  logic [NREG-1:0] mask;
  logic [AW-1:0]   base;
  logic            stall, done, mreq, mwe;
  logic [AW-1:0]   maddr;
  logic [1:0]      lane, rwe, rre;
  logic [IW-1:0]   idx0, idx1;

  lsm_seq #(.NREG(NREG), .AW(AW), .IW(IW)) i_lsm_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .mask_i(mask), .base_i(base), .stall_o(stall), .done_o(done),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_lane_o(lane),
    .rf_we_o(rwe), .rf_re_o(rre), .rf_idx0_o(idx0), .rf_idx1_o(idx1)
  );

  typedef struct {
    bit          req;
    bit          last;
    bit          st;
    bit          unal;
    bit          first;
    logic [31:0] addr;
    logic [1:0]  ln;
    int          i0;
    int          i1;
    int          nb;
  } exp_t;

  exp_t q[$];
  int   nchk = 0, nerr = 0, beats = 0;
  bit   busy_now = 0;

  task automatic chk(string r, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic push(bit st, logic [NREG-1:0] m, logic [AW-1:0] b);
    int   regs[$];
    int   n, j;
    logic [31:0] a;
    bit   unal, first;
    exp_t e;
    for (int k = 0; k < NREG; k++) if (m[k]) regs.push_back(k);
    n = regs.size();
    if (n == 0) begin
      e = '{req: 0, last: 1, st: st, unal: 0, first: 0, addr: 0, ln: 0, i0: 0, i1: 0, nb: 0};
      q.push_back(e);
      return;
    end
    a = b & ~32'd3;
    unal = a[2];
    first = 1;
    j = 0;
    while (j < n) begin
      e = '{req: 1, last: 0, st: st, unal: unal, first: first, addr: a & ~32'd7,
            ln: 0, i0: 0, i1: 0, nb: unal ? (n / 2 + 1) : ((n + 1) / 2)};
      if (a[2]) begin
        e.ln = 2'b10; e.i1 = regs[j]; j++; a = a + 4;
      end else begin
        e.ln = 2'b01; e.i0 = regs[j]; j++;
        if (j < n) begin e.ln = 2'b11; e.i1 = regs[j]; j++; end
        a = a + 8;
      end
      e.last = (j == n);
      first = 0;
      q.push_back(e);
    end
  endtask

  task automatic check();
    exp_t e;
    string lr;
    if (q.size() > 0) e = q.pop_front();
    else e = '{req: 0, last: 0, st: 0, unal: 0, first: 0, addr: 0, ln: 0, i0: 0, i1: 0, nb: 0};
    busy_now = e.req;
    chk("R2", "mem_req", longint'(mreq), longint'(e.req));
    chk("R2", "stall", longint'(stall), longint'(e.req && !e.last));
    chk(e.req ? "R6" : "R7", "done", longint'(done), longint'(e.last));
    if (e.req) begin
      lr = (e.unal && e.first) ? "R5" : "R4";
      chk("R10", "addr", longint'(maddr), longint'(e.addr));
      chk(lr, "lane", longint'(lane), longint'(e.ln));
      chk("R8", "mem_we", longint'(mwe), longint'(e.st));
      chk("R8", "rf_we", longint'(rwe), longint'(e.st ? 2'b00 : e.ln));
      chk("R8", "rf_re", longint'(rre), longint'(e.st ? e.ln : 2'b00));
      if (e.ln[0]) chk("R3", "idx0", longint'(idx0), longint'(e.i0));
      if (e.ln[1]) chk("R3", "idx1", longint'(idx1), longint'(e.i1));
      beats++;
      if (e.last) begin
        chk(e.unal ? "R5" : "R4", "beat count", longint'(beats), longint'(e.nb));
        beats = 0;
      end
    end else begin
      chk("R7", "lane idle", longint'(lane), 0);
      chk("R8", "strobes idle", longint'({rwe, rre}), 0);
    end
  endtask

  task automatic cyc();
    if (rst_n && start && !busy_now) push(store, mask, base);
    @(negedge clk);
    check();
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
    cyc();
  endtask

  task automatic go(bit st, logic [NREG-1:0] m, logic [AW-1:0] b);
    start = 1; store = st; mask = m; base = b & ~32'd3;
    cyc();
    start = 0; mask = '0; base = '0;
    drain();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    rst_n = 0; start = 0; store = 0; mask = '0; base = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset outputs", longint'({mreq, stall, done, lane, rwe, rre}), 0);
    end
    rst_n = 1;
    cyc();
    // aligned, even and odd counts
    go(0, 16'h00F0, 32'h1000);
    go(1, 16'h0007, 32'h2000);
    go(0, 16'hFFFF, 32'h0040);
    go(1, 16'h8001, 32'h0100);
    // unaligned base
    go(0, 16'h00F0, 32'h1004);
    go(1, 16'h0007, 32'h2004);
    go(0, 16'hFFFF, 32'h0044);
    go(1, 16'h0400, 32'h0304);
    go(0, 16'h0001, 32'h0308);
    // empty mask
    go(1, 16'h0000, 32'h0500);
    // empty followed by a start in the done cycle
    start = 1; store = 0; mask = '0; base = 32'h600;
    cyc();
    mask = 16'h0C30; base = 32'h704;
    cyc();
    start = 0;
    drain();
    // R9: start pulses during a running transfer are ignored
    start = 1; store = 1; mask = 16'hAAAA; base = 32'h800;
    cyc();
    mask = 16'h5555; base = 32'h904;
    cyc();
    cyc();
    start = 0;
    drain();
    // random mixes
    for (int t = 0; t < 60; t++) begin
      logic [AW-1:0] b;
      b = ($urandom & 32'h0000FFF8) | (($urandom & 1) ? 32'd4 : 32'd0);
      go(bit'($urandom & 1), NREG'($urandom), b);
      repeat ($urandom % 3) cyc();
    end
    finish_run();
  end
endmodule